// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a CPU that reports each bus cycle as a 3-bit status code instead of driving its own control strobes. It watches that code on every rising clock edge. When the code leaves the idle (passive) value, it runs a fixed T1..T4 sequence and produces the strobes the rest of the system needs: memory and IO read/write commands, early ("advanced") write commands, interrupt acknowledge, address latch enable, data buffer enable and data direction. It also produces one auxiliary output whose meaning is picked by a strap input.

All outputs are active high except the direction output. That output is high when data is transmitted by the CPU and low when data is received. Command strobes pass only while the address enable input is low and the command enable input is high. The latch, buffer-enable and direction outputs ignore those two inputs. There are no streaming interfaces: every pin is a plain control or status pin.

Timing is counted from the start edge. The start edge is the rising clock edge at which a non-passive code is first sampled after an edge that sampled the passive code. T1 is the clock period that follows the start edge. T2, T3 and T4 are the next three periods. The cycle then stays parked until the status returns to passive.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is held, and before any cycle starts, all command strobes, the latch enable, the buffer enable and the auxiliary output are low, and the direction output is high.
- R2: A cycle starts only at an edge that samples a non-passive code (anything but 111) right after an edge that sampled 111. The latch enable is high for exactly the T1 period. A change from one non-passive code to another starts nothing and keeps the code captured at the start edge.
- R3: The captured code selects the command: 000 interrupt acknowledge, 001 IO read, 010 IO write plus early IO write, 011 halt (no command), 100 and 101 memory read, 110 memory write plus early memory write. At most one command class is active at a time.
- R4: Read commands, interrupt acknowledge and early write commands are high during T2 and T3 and low from T4 on.
- R5: A normal write command is high during T3 only, one clock after its early write, and is low from T4 on.
- R6: The buffer enable is high during T2 and T3 of every cycle except a halt cycle (011), which never raises it.
- R7: The direction output is low from T1 through T4 of cycles with codes 000, 001, 100 or 101, and high at all other times.
- R8: Command strobes are forced low while the address enable input is high or the command enable input is low. The latch enable, buffer enable and direction outputs are unaffected by these two inputs.
- R9: With the strap low, the auxiliary output is high only in T1 of an interrupt acknowledge cycle (cascade enable). With the strap high, it is high only while the buffer enable is high in an IO read or IO write cycle (peripheral data enable).
- R10: An edge that samples the passive code ends the cycle at once, so every cycle output is inactive in the following period. After T4, nothing further happens until the passive code is sampled.
- R11: Two interrupt acknowledge cycles separated by passive status give two separate interrupt acknowledge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_status_i | input | 3 | CPU bus cycle status code |
| aen_n_i | input | 1 | Address enable, active low; high blocks the commands |
| cen_i | input | 1 | Command enable, active high |
| iob_i | input | 1 | Strap selecting cascade enable (0) or peripheral data enable (1) |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| mem_wr_early_o | output | 1 | Early memory write command |
| io_rd_o | output | 1 | IO read command |
| io_wr_o | output | 1 | IO write command |
| io_wr_early_o | output | 1 | Early IO write command |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| addr_latch_o | output | 1 | Address latch enable |
| data_en_o | output | 1 | Data buffer enable |
| dir_tx_o | output | 1 | Data direction, 1 = transmit, 0 = receive |
| casc_pden_o | output | 1 | Cascade enable or peripheral data enable |

## Verification
The hardest behaviour to reach from the ports is a cycle that does not run its normal course. This covers status that returns to passive in the middle of T2 or T3, and status that jumps between two non-passive codes without passing through 111. The stimulus reaches these cases by holding each random code for a random 1 to 7 clocks and by sometimes swapping the code mid-cycle. Directed sequences then pin down the abort, the back-to-back interrupt acknowledge pair, and a read with the commands blocked while the buffer enable still runs.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [2:0] {
    ST_INTA    = 3'b000,
    ST_IO_RD   = 3'b001,
    ST_IO_WR   = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEM_RD  = 3'b101,
    ST_MEM_WR  = 3'b110,
    ST_PASSIVE = 3'b111
  } bus_code_e;

  localparam int unsigned NUM_CMDS = 7;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic mem_wr_early;
    logic io_rd;
    logic io_wr;
    logic io_wr_early;
    logic irq_ack;
  } cmd_set_t;

  function automatic logic is_receive(input bus_code_e c);
    return (c == ST_INTA) || (c == ST_IO_RD) || (c == ST_FETCH) || (c == ST_MEM_RD);
  endfunction

  function automatic logic is_io_xfer(input bus_code_e c);
    return (c == ST_IO_RD) || (c == ST_IO_WR);
  endfunction

endpackage

// File: rtl/bcg_cycle_tracker.sv
module bcg_cycle_tracker
  import bcg_pkg::*;
#(
  parameter int unsigned CMD_CYCLES = 2,
  localparam int unsigned LAST_PHASE = CMD_CYCLES + 3,
  localparam int unsigned CNT_W = $clog2(LAST_PHASE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       status_i,
  output logic [CNT_W-1:0] phase_o,
  output bus_code_e        code_o
);

  localparam logic [CNT_W-1:0] PH_IDLE = CNT_W'(0);
  localparam logic [CNT_W-1:0] PH_T1   = CNT_W'(1);
  localparam logic [CNT_W-1:0] PH_DONE = CNT_W'(LAST_PHASE);

  bus_code_e        prev_q;
  bus_code_e        code_q;
  logic [CNT_W-1:0] phase_q;
  bus_code_e        status_c;

  assign status_c = bus_code_e'(status_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= ST_PASSIVE;
      code_q  <= ST_PASSIVE;
      phase_q <= PH_IDLE;
    end else begin
      prev_q <= status_c;
      if (status_c == ST_PASSIVE) begin
        phase_q <= PH_IDLE;
      end else if (phase_q == PH_IDLE) begin
        if (prev_q == ST_PASSIVE) begin
          phase_q <= PH_T1;
          code_q  <= status_c;
        end
      end else if (phase_q != PH_DONE) begin
        phase_q <= phase_q + CNT_W'(1);
      end
    end
  end

  assign phase_o = phase_q;
  assign code_o  = code_q;

  AST_START_FROM_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1) |-> ($past(prev_q) == ST_PASSIVE)); // R2

  AST_PASSIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_c == ST_PASSIVE) |=> (phase_q == PH_IDLE)); // R10

endmodule

// File: rtl/bcg_strobe_gen.sv
module bcg_strobe_gen
  import bcg_pkg::*;
#(
  parameter int unsigned CMD_CYCLES = 2,
  parameter int unsigned WR_DELAY   = 1,
  localparam int unsigned LAST_PHASE = CMD_CYCLES + 3,
  localparam int unsigned CNT_W = $clog2(LAST_PHASE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] phase_i,
  input  bus_code_e        code_i,
  output cmd_set_t         cmd_o,
  output logic             ale_o,
  output logic             den_o,
  output logic             dir_tx_o
);

  localparam logic [CNT_W-1:0] PH_T1    = CNT_W'(1);
  localparam logic [CNT_W-1:0] PH_WIN_A = CNT_W'(2);
  localparam logic [CNT_W-1:0] PH_WIN_B = CNT_W'(CMD_CYCLES + 1);
  localparam logic [CNT_W-1:0] PH_LATE  = CNT_W'(2 + WR_DELAY);
  localparam logic [CNT_W-1:0] PH_T4    = CNT_W'(CMD_CYCLES + 2);

  logic win, late, active;

  assign win    = (phase_i >= PH_WIN_A) && (phase_i <= PH_WIN_B);
  assign late   = (phase_i >= PH_LATE)  && (phase_i <= PH_WIN_B);
  assign active = (phase_i >= PH_T1)    && (phase_i <= PH_T4);

  always_comb begin
    cmd_o = '0;
    unique case (code_i)
      ST_INTA:   cmd_o.irq_ack = win;
      ST_IO_RD:  cmd_o.io_rd   = win;
      ST_IO_WR: begin
        cmd_o.io_wr_early = win;
        cmd_o.io_wr       = late;
      end
      ST_FETCH,
      ST_MEM_RD: cmd_o.mem_rd  = win;
      ST_MEM_WR: begin
        cmd_o.mem_wr_early = win;
        cmd_o.mem_wr       = late;
      end
      default: cmd_o = '0;
    endcase
  end

  assign ale_o    = (phase_i == PH_T1);
  assign den_o    = win && (code_i != ST_HALT);
  assign dir_tx_o = !(active && is_receive(code_i));

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_o.mem_rd, cmd_o.mem_wr_early, cmd_o.io_rd,
                cmd_o.io_wr_early, cmd_o.irq_ack}) <= 1); // R3

  AST_WR_AFTER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_o.mem_wr) |-> $past(cmd_o.mem_wr_early)); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == ST_HALT) |-> (!den_o && (cmd_o == '0))); // R6

endmodule

// File: rtl/bcg_aux_enable.sv
module bcg_aux_enable
  import bcg_pkg::*;
(
  input  logic      iob_i,
  input  logic      ale_i,
  input  logic      den_i,
  input  bus_code_e code_i,
  output logic      aux_o
);

  always_comb begin
    if (iob_i) aux_o = den_i && is_io_xfer(code_i);
    else       aux_o = ale_i && (code_i == ST_INTA);
  end

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
#(
  parameter int unsigned CMD_CYCLES = 2,
  parameter int unsigned WR_DELAY   = 1,
  localparam int unsigned LAST_PHASE = CMD_CYCLES + 3,
  localparam int unsigned CNT_W = $clog2(LAST_PHASE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_status_i,
  input  logic       aen_n_i,
  input  logic       cen_i,
  input  logic       iob_i,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       mem_wr_early_o,
  output logic       io_rd_o,
  output logic       io_wr_o,
  output logic       io_wr_early_o,
  output logic       irq_ack_o,
  output logic       addr_latch_o,
  output logic       data_en_o,
  output logic       dir_tx_o,
  output logic       casc_pden_o
);

  logic [CNT_W-1:0]    phase;
  bus_code_e           code;
  cmd_set_t            raw_cmd;
  logic [NUM_CMDS-1:0] raw_vec, gated_vec;
  logic                cmd_allow;

  bcg_cycle_tracker #(.CMD_CYCLES(CMD_CYCLES)) u_track (
    .clk(clk), .rst_n(rst_n), .status_i(bus_status_i),
    .phase_o(phase), .code_o(code)
  );

  bcg_strobe_gen #(.CMD_CYCLES(CMD_CYCLES), .WR_DELAY(WR_DELAY)) u_strobe (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .code_i(code),
    .cmd_o(raw_cmd), .ale_o(addr_latch_o), .den_o(data_en_o), .dir_tx_o(dir_tx_o)
  );

  bcg_aux_enable u_aux (
    .iob_i(iob_i), .ale_i(addr_latch_o), .den_i(data_en_o),
    .code_i(code), .aux_o(casc_pden_o)
  );

  assign cmd_allow = !aen_n_i && cen_i;
  assign raw_vec   = raw_cmd;

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_gate
    assign gated_vec[i] = raw_vec[i] & cmd_allow;
  end

  assign {mem_rd_o, mem_wr_o, mem_wr_early_o, io_rd_o,
          io_wr_o, io_wr_early_o, irq_ack_o} = gated_vec;

  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (aen_n_i || !cen_i) |-> !(mem_rd_o || mem_wr_o || mem_wr_early_o || io_rd_o ||
                              io_wr_o || io_wr_early_o || irq_ack_o)); // R8

  AST_READ_RECEIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || io_rd_o || irq_ack_o) |-> !dir_tx_o); // R7

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |=> !addr_latch_o); // R2

endmodule

// File: tb/bus_cmd_gen_test.sv
module bus_cmd_gen_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] st = 3'b111;
  logic aen_n = 1'b0, cen = 1'b1, iob = 1'b0;
  logic mem_rd, mem_wr, mem_wr_e, io_rd, io_wr, io_wr_e, irq_ack, ale, den, dir_tx, aux;

  int errors = 0;
  int checks = 0;
  int m_cnt = 0;
  logic [2:0] m_code = 3'b111;
  logic m_prev_pass = 1'b1;
  int ack_pulses = 0;
  logic ack_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_status_i(st), .aen_n_i(aen_n), .cen_i(cen), .iob_i(iob),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wr_early_o(mem_wr_e), .io_rd_o(io_rd),
    .io_wr_o(io_wr), .io_wr_early_o(io_wr_e), .irq_ack_o(irq_ack), .addr_latch_o(ale),
    .data_en_o(den), .dir_tx_o(dir_tx), .casc_pden_o(aux)
  );

  function automatic logic [10:0] expect_out(int cnt, logic [2:0] c, logic a_n, logic ce, logic sb);
    logic win, t3, t1, act, en, rx, dn;
    win = (cnt == 2) || (cnt == 3);
    t3  = (cnt == 3);
    t1  = (cnt == 1);
    act = (cnt >= 1) && (cnt <= 4);
    en  = !a_n && ce;
    rx  = (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
    dn  = win && (c != 3'b011);
    return { win && (c == 3'b100 || c == 3'b101) && en,
             t3  && (c == 3'b110) && en,
             win && (c == 3'b110) && en,
             win && (c == 3'b001) && en,
             t3  && (c == 3'b010) && en,
             win && (c == 3'b010) && en,
             win && (c == 3'b000) && en,
             t1,
             dn,
             !(act && rx),
             sb ? (dn && (c == 3'b001 || c == 3'b010)) : (t1 && c == 3'b000) };
  endfunction

  function automatic string bit_tag(int b);
    case (b)
      10: return "R4 mem_rd";   9: return "R5 mem_wr";  8: return "R4 mem_wr_early";
      7:  return "R4 io_rd";    6: return "R5 io_wr";   5: return "R4 io_wr_early";
      4:  return "R3 irq_ack";  3: return "R2 ale";      2: return "R6 den";
      1:  return "R7 dir_tx";   default: return "R9 casc_pden";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] outs();
    return {mem_rd, mem_wr, mem_wr_e, io_rd, io_wr, io_wr_e, irq_ack, ale, den, dir_tx, aux};
  endfunction

  task automatic check_all();
    logic [10:0] e, a;
    e = expect_out(m_cnt, m_code, aen_n, cen, iob);
    a = outs();
    for (int b = 0; b < 11; b++) check(bit_tag(b), 32'(a[b]), 32'(e[b]));
  endtask

  task automatic step(logic [2:0] s, logic a_n, logic ce, logic sb);
    st = s; aen_n = a_n; cen = ce; iob = sb;
    @(posedge clk);
    if (s == 3'b111) m_cnt = 0;
    else if (m_cnt == 0) begin
      if (m_prev_pass) begin m_cnt = 1; m_code = s; end
    end else if (m_cnt < 5) m_cnt++;
    m_prev_pass = (s == 3'b111);
    @(negedge clk);
    check_all();
    if (irq_ack && !ack_prev) ack_pulses++;
    ack_prev = irq_ack;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs during reset", 32'(outs()), 32'(11'b00000000010));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", 32'(outs()), 32'(11'b00000000010));

    // R3 R4 R5: each code once, fully enabled
    for (int c = 0; c < 7; c++) begin
      step(3'b111, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) step(3'(c), 1'b0, 1'b1, 1'b0);
    end

    // R10: abort a memory read in T2
    step(3'b111, 1'b0, 1'b1, 1'b0);
    step(3'b101, 1'b0, 1'b1, 1'b0);
    step(3'b101, 1'b0, 1'b1, 1'b0);
    check("R10 mem_rd in T2 before abort", 32'(mem_rd), 32'd1);
    step(3'b111, 1'b0, 1'b1, 1'b0);
    check("R10 all idle after abort", 32'(outs()), 32'(11'b00000000010));

    // R2: swap to another non-passive code mid-cycle
    step(3'b001, 1'b0, 1'b1, 1'b1);
    step(3'b110, 1'b0, 1'b1, 1'b1);
    check("R2 swapped code keeps io read", 32'(io_rd), 32'd1);
    check("R2 swapped code no mem write", 32'(mem_wr_e), 32'd0);
    for (int k = 0; k < 4; k++) step(3'b110, 1'b0, 1'b1, 1'b1);
    check("R10 parked after T4", 32'(outs()), 32'(11'b00000000010));

    // R8: memory read with commands blocked
    step(3'b111, 1'b0, 1'b1, 1'b0);
    step(3'b100, 1'b1, 1'b1, 1'b0);
    step(3'b100, 1'b1, 1'b1, 1'b0);
    check("R8 blocked mem_rd", 32'(mem_rd), 32'd0);
    check("R8 den unaffected", 32'(den), 32'd1);
    step(3'b100, 1'b0, 1'b0, 1'b0);
    check("R8 cen low blocks mem_rd", 32'(mem_rd), 32'd0);

    // R11: two acknowledge cycles
    ack_pulses = 0;
    for (int n = 0; n < 2; n++) begin
      step(3'b111, 1'b0, 1'b1, 1'b0);
      step(3'b111, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 5; k++) step(3'b000, 1'b0, 1'b1, 1'b0);
    end
    step(3'b111, 1'b0, 1'b1, 1'b0);
    check("R11 two irq_ack pulses", 32'(ack_pulses), 32'd2);

    // Random cycles: R2..R10
    for (int n = 0; n < 400; n++) begin
      logic [2:0] code;
      logic a_n, ce, sb;
      int len;
      code = 3'($urandom_range(0, 6));
      len  = $urandom_range(1, 7);
      sb   = 1'($urandom_range(0, 1));
      a_n  = ($urandom_range(0, 7) == 0);
      ce   = ($urandom_range(0, 7) != 0);
      repeat ($urandom_range(1, 2)) step(3'b111, a_n, ce, sb);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 15) == 0) code = 3'($urandom_range(0, 6));
        step(code, a_n, ce, sb);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule